// File: doc/BRIEF.md
# Configurable UART with Three-Entry Receive Queue

This block is a full-duplex asynchronous serial port whose character format is set at run time. A character has 5 to 9 data bits, sent least significant bit first. It can carry an optional parity bit in one of four modes, followed by one or two stop bits. The transmitter adds the start bit, the parity bit and the stop bits itself. The receiver strips them, checks the parity bit and checks the first stop bit.

A single timer sets the line rate. The timer counts up from a reload value on every enable pulse from a power-of-two prescaler. Each time it overflows it produces one oversample tick. A bit lasts eight ticks in both directions. The receiver samples the line in the middle of each bit. Received characters wait in a three-entry first-in first-out queue. Each entry keeps its own parity-error and framing-error flags. A character that completes while the queue is full is dropped and raises a sticky overrun flag.

Top module: `cfg_uart`

## Requirements
- R1: While reset is applied and in the first cycle after it, `txd` is 1, `txIdle` is 1, `rxAvail` is 0 and `rxOverrun` is 0.
- R2: A `txWrite` pulse while `txIdle` is 1 starts a frame in the next cycle. The frame is a low start bit, then `cfgLen`+5 data bits of `txData` (LSB first), the parity bit when enabled, and high stop bits. `txIdle` stays 0 until the frame ends. A `txWrite` pulse while `txIdle` is 0 is ignored, and no second frame follows.
- R3: The `cfgParity` codes are: 0 no parity bit, 1 odd, 2 even, 3 always 1 (mark), 4 always 0 (space). Odd and even are computed over the data bits actually sent.
- R4: `cfgStop2`=0 sends one stop bit and `cfgStop2`=1 sends two. `txIdle` returns to 1 at the end of the last stop bit.
- R5: The oversample tick period is (65536 − `cfgReload`) × 2^`cfgPrescale` clock cycles. One bit lasts 8 ticks. The start bit may be shorter than a full bit by less than one tick.
- R6: A received frame with the configured format is stored with its data bits right-aligned in `rxData`. The unused upper bits of `rxData` read 0.
- R7: The receiver compares the received parity bit with the value R3 defines for the received data. `rxParErr` shows the result for the entry at the head of the queue.
- R8: A low first stop bit sets `rxFrameErr` for that entry. The receiver then waits for the line to return high before it looks for a new start bit.
- R9: A low pulse on `rxd` that has ended before the middle of the start bit stores nothing.
- R10: The queue holds up to 3 entries in arrival order. The head entry is visible while `rxAvail` is 1, and an `rxRead` pulse removes it.
- R11: A frame that completes while 3 entries are held is discarded, and `rxOverrun` is set. `rxOverrun` stays 1 until the next `rxRead`, which clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| cfgLen | input | 3 | Data length code, bits = code + 5 (0..4) |
| cfgParity | input | 3 | Parity mode code (R3) |
| cfgStop2 | input | 1 | 1 selects two transmitted stop bits |
| cfgPrescale | input | 2 | Prescaler exponent, divide by 2^n |
| cfgReload | input | 16 | Rate timer reload value |
| txData | input | 9 | Character to transmit |
| txWrite | input | 1 | Transmit request pulse |
| txIdle | output | 1 | Transmitter idle |
| txd | output | 1 | Serial transmit line |
| rxd | input | 1 | Serial receive line |
| rxRead | input | 1 | Removes the head entry of the receive queue |
| rxData | output | 9 | Head entry data, right-aligned |
| rxAvail | output | 1 | Receive queue not empty |
| rxParErr | output | 1 | Parity error flag of the head entry |
| rxFrameErr | output | 1 | Framing error flag of the head entry |
| rxOverrun | output | 1 | Sticky overrun flag |

## Verification
A wrong count in the transmit bit counter or a wrong shift-register position shows on `txd` within one bit time. Either a wrong data bit or a wrong parity bit is sampled, or the stop bit arrives in the wrong slot, or `txIdle` rises early or late.

A fault in the receiver state appears at the queue head about half a bit after the stop bit. The result is wrong alignment, a wrong error flag, or a missing or extra entry. The bench's queue model catches the extra or missing entry in the next idle cycle of the line.

Wrong queue pointer or occupancy handling shows as out-of-order data, or as an overrun that is missing or appears too early, when a fourth frame arrives or when the queue is read.

// File: rtl/uart_pkg.sv
package uart_pkg;
  localparam int DATA_W   = 9;
  localparam int MIN_BITS = 5;

  localparam logic [2:0] PAR_NONE  = 3'd0;
  localparam logic [2:0] PAR_ODD   = 3'd1;
  localparam logic [2:0] PAR_EVEN  = 3'd2;
  localparam logic [2:0] PAR_MARK  = 3'd3;
  localparam logic [2:0] PAR_SPACE = 3'd4;

  typedef enum logic [2:0] {
    LINE_IDLE, LINE_START, LINE_DATA, LINE_PARITY, LINE_STOP
  } txSel_t;

  typedef enum logic [2:0] {
    RX_IDLE, RX_START, RX_DATA, RX_PARITY, RX_STOP, RX_BREAK
  } rxState_t;

  typedef struct packed {
    txSel_t txSel;
    logic   txLoad;
    logic   txShift;
    logic   rxBegin;
    logic   rxShift;
    logic   rxParChk;
    logic   rxPush;
  } strobe_t;

  typedef struct packed {
    logic              frameErr;
    logic              parErr;
    logic [DATA_W-1:0] data;
  } rxEntry_t;

  function automatic logic [2:0] clampLen(input logic [2:0] code);
    return (code > 3'd4) ? 3'd4 : code;
  endfunction

  function automatic logic parityOf(input logic [2:0] mode, input logic [DATA_W-1:0] bits);
    case (mode)
      PAR_ODD:  return ~(^bits);
      PAR_EVEN: return ^bits;
      PAR_MARK: return 1'b1;
      default:  return 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/uart_baud.sv
module uart_baud #(
  parameter int TW = 16,
  parameter int PW = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [TW-1:0] reload,
  input  logic [PW-1:0] preSel,
  output logic          tick
);
  localparam int PRE_BITS = (1 << PW) - 1;

  logic [PRE_BITS-1:0] preCnt;
  logic [PRE_BITS-1:0] preMask;
  logic                preEn;
  logic [TW-1:0]       timer;

  assign preMask = PRE_BITS'((1 << preSel) - 1);
  assign preEn   = ((preCnt & preMask) == preMask);
  assign tick    = preEn && (timer == {TW{1'b1}});

  always_ff @(posedge clk) begin
    if (rst) preCnt <= '0;
    else     preCnt <= preCnt + PRE_BITS'(1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      timer <= {TW{1'b1}};
    end else if (preEn) begin
      if (timer == {TW{1'b1}}) timer <= reload;
      else                     timer <= timer + TW'(1);
    end
  end
endmodule

// File: rtl/uart_ctrl.sv
module uart_ctrl
  import uart_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       tick,
  input  logic       txWrite,
  input  logic [2:0] lenSel,
  input  logic       parEn,
  input  logic       stop2,
  input  logic       rxLine,
  output strobe_t    stb,
  output logic       txIdle
);
  txSel_t     txState;
  logic [2:0] txSub;
  logic [3:0] txCnt;
  logic       txStopCnt;
  logic       txEnd;

  rxState_t   rxState;
  logic [2:0] rxSub;
  logic [3:0] rxCnt;
  logic       rxSamp;

  logic [3:0] lastIdx;

  assign lastIdx = {1'b0, clampLen(lenSel)} + 4'd4;
  assign txEnd   = tick && (txSub == 3'd7);
  assign rxSamp  = tick && (rxSub == 3'd7);
  assign txIdle  = (txState == LINE_IDLE);

  // transmit sequencing
  always_ff @(posedge clk) begin
    if (rst) begin
      txState   <= LINE_IDLE;
      txSub     <= '0;
      txCnt     <= '0;
      txStopCnt <= 1'b0;
    end else if (txState == LINE_IDLE) begin
      if (txWrite) begin
        txState <= LINE_START;
        txSub   <= '0;
      end
    end else begin
      if (tick) txSub <= txSub + 3'd1;
      if (txEnd) begin
        case (txState)
          LINE_START: begin
            txState <= LINE_DATA;
            txCnt   <= '0;
          end
          LINE_DATA: begin
            if (txCnt == lastIdx) begin
              txState   <= parEn ? LINE_PARITY : LINE_STOP;
              txStopCnt <= 1'b0;
            end else begin
              txCnt <= txCnt + 4'd1;
            end
          end
          LINE_PARITY: begin
            txState   <= LINE_STOP;
            txStopCnt <= 1'b0;
          end
          default: begin
            if (stop2 && !txStopCnt) txStopCnt <= 1'b1;
            else                     txState   <= LINE_IDLE;
          end
        endcase
      end
    end
  end

  // receive sequencing
  always_ff @(posedge clk) begin
    if (rst) begin
      rxState <= RX_IDLE;
      rxSub   <= '0;
      rxCnt   <= '0;
    end else begin
      case (rxState)
        RX_IDLE: begin
          if (tick && !rxLine) begin
            rxState <= RX_START;
            rxSub   <= '0;
          end
        end
        RX_START: begin
          if (tick) begin
            if (rxSub == 3'd3) begin
              rxSub <= '0;
              rxCnt <= '0;
              rxState <= rxLine ? RX_IDLE : RX_DATA;
            end else begin
              rxSub <= rxSub + 3'd1;
            end
          end
        end
        RX_DATA: begin
          if (tick) rxSub <= rxSub + 3'd1;
          if (rxSamp) begin
            if (rxCnt == lastIdx) rxState <= parEn ? RX_PARITY : RX_STOP;
            else                  rxCnt   <= rxCnt + 4'd1;
          end
        end
        RX_PARITY: begin
          if (tick) rxSub <= rxSub + 3'd1;
          if (rxSamp) rxState <= RX_STOP;
        end
        RX_STOP: begin
          if (tick) rxSub <= rxSub + 3'd1;
          if (rxSamp) rxState <= rxLine ? RX_IDLE : RX_BREAK;
        end
        default: begin
          if (rxLine) rxState <= RX_IDLE;
        end
      endcase
    end
  end

  always_comb begin
    stb          = '0;
    stb.txSel    = txState;
    stb.txLoad   = (txState == LINE_IDLE) && txWrite;
    stb.txShift  = (txState == LINE_DATA) && txEnd;
    stb.rxBegin  = (rxState == RX_START) && tick && (rxSub == 3'd3) && !rxLine;
    stb.rxShift  = (rxState == RX_DATA) && rxSamp;
    stb.rxParChk = (rxState == RX_PARITY) && rxSamp;
    stb.rxPush   = (rxState == RX_STOP) && rxSamp;
  end
endmodule

// File: rtl/uart_dpath.sv
module uart_dpath
  import uart_pkg::*;
#(
  parameter int DEPTH = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  strobe_t           stb,
  input  logic [2:0]        lenSel,
  input  logic [2:0]        parMode,
  input  logic [DATA_W-1:0] txData,
  input  logic              rxd,
  input  logic              rxRead,
  output logic              txd,
  output logic              rxLine,
  output logic [DATA_W-1:0] rxData,
  output logic              rxAvail,
  output logic              rxParErr,
  output logic              rxFrameErr,
  output logic              rxOverrun
);
  localparam int CW = $clog2(DEPTH + 1);
  localparam int PW = $clog2(DEPTH);
  localparam logic [CW-1:0] FULL = CW'(DEPTH);
  localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);

  logic [3:0]        shAmt;
  logic [DATA_W-1:0] dataMask;
  logic [DATA_W-1:0] txShreg;
  logic              txParBit;
  logic [1:0]        rxSync;
  logic [DATA_W-1:0] rxShreg;
  logic [DATA_W-1:0] rxAligned;
  logic              rxPerrCur;
  rxEntry_t          newEntry;
  rxEntry_t          slots [DEPTH];
  logic [PW-1:0]     wrPtr, rdPtr;
  logic [CW-1:0]     count;
  logic              pop, accept;

  assign shAmt     = 4'(DATA_W - MIN_BITS) - {1'b0, clampLen(lenSel)};
  assign dataMask  = {DATA_W{1'b1}} >> shAmt;
  assign rxAligned = rxShreg >> shAmt;

  // transmit shift path
  always_ff @(posedge clk) begin
    if (rst) begin
      txShreg  <= '0;
      txParBit <= 1'b0;
    end else if (stb.txLoad) begin
      txShreg  <= txData;
      txParBit <= parityOf(parMode, txData & dataMask);
    end else if (stb.txShift) begin
      txShreg  <= txShreg >> 1;
    end
  end

  always_comb begin
    case (stb.txSel)
      LINE_START:  txd = 1'b0;
      LINE_DATA:   txd = txShreg[0];
      LINE_PARITY: txd = txParBit;
      default:     txd = 1'b1;
    endcase
  end

  // receive sampling path
  always_ff @(posedge clk) begin
    if (rst) rxSync <= 2'b11;
    else     rxSync <= {rxSync[0], rxd};
  end
  assign rxLine = rxSync[1];

  always_ff @(posedge clk) begin
    if (rst) begin
      rxShreg   <= '0;
      rxPerrCur <= 1'b0;
    end else begin
      if (stb.rxBegin)  rxPerrCur <= 1'b0;
      if (stb.rxShift)  rxShreg   <= {rxLine, rxShreg[DATA_W-1:1]};
      if (stb.rxParChk) rxPerrCur <= (rxLine != parityOf(parMode, rxAligned));
    end
  end

  assign newEntry = '{frameErr: !rxLine, parErr: rxPerrCur, data: rxAligned};

  // receive queue
  assign pop    = rxRead && (count != '0);
  assign accept = stb.rxPush && ((count != FULL) || pop);

  for (genvar g = 0; g < DEPTH; g++) begin : gSlot
    always_ff @(posedge clk) begin
      if (rst)                                slots[g] <= '0;
      else if (accept && (wrPtr == PW'(g)))   slots[g] <= newEntry;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wrPtr     <= '0;
      rdPtr     <= '0;
      count     <= '0;
      rxOverrun <= 1'b0;
    end else begin
      if (accept) wrPtr <= (wrPtr == LAST) ? '0 : wrPtr + PW'(1);
      if (pop)    rdPtr <= (rdPtr == LAST) ? '0 : rdPtr + PW'(1);
      if (accept && !pop)      count <= count + CW'(1);
      else if (pop && !accept) count <= count - CW'(1);
      if (stb.rxPush && !accept) rxOverrun <= 1'b1;
      else if (rxRead)           rxOverrun <= 1'b0;
    end
  end

  assign rxAvail    = (count != '0);
  assign rxData     = slots[rdPtr].data;
  assign rxParErr   = slots[rdPtr].parErr;
  assign rxFrameErr = slots[rdPtr].frameErr;
endmodule

// File: rtl/cfg_uart.sv
module cfg_uart
  import uart_pkg::*;
#(
  parameter int RELOAD_W = 16,
  parameter int PRE_W    = 2,
  parameter int RX_DEPTH = 3
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [2:0]          cfgLen,
  input  logic [2:0]          cfgParity,
  input  logic                cfgStop2,
  input  logic [PRE_W-1:0]    cfgPrescale,
  input  logic [RELOAD_W-1:0] cfgReload,
  input  logic [DATA_W-1:0]   txData,
  input  logic                txWrite,
  output logic                txIdle,
  output logic                txd,
  input  logic                rxd,
  input  logic                rxRead,
  output logic [DATA_W-1:0]   rxData,
  output logic                rxAvail,
  output logic                rxParErr,
  output logic                rxFrameErr,
  output logic                rxOverrun
);
  logic    tick;
  logic    rxLine;
  strobe_t stb;

  uart_baud #(.TW(RELOAD_W), .PW(PRE_W)) uBaud (
    .clk(clk), .rst(rst), .reload(cfgReload), .preSel(cfgPrescale), .tick(tick)
  );

  uart_ctrl uCtrl (
    .clk(clk), .rst(rst), .tick(tick), .txWrite(txWrite), .lenSel(cfgLen),
    .parEn(cfgParity != PAR_NONE), .stop2(cfgStop2), .rxLine(rxLine),
    .stb(stb), .txIdle(txIdle)
  );

  uart_dpath #(.DEPTH(RX_DEPTH)) uDpath (
    .clk(clk), .rst(rst), .stb(stb), .lenSel(cfgLen), .parMode(cfgParity),
    .txData(txData), .rxd(rxd), .rxRead(rxRead), .txd(txd), .rxLine(rxLine),
    .rxData(rxData), .rxAvail(rxAvail), .rxParErr(rxParErr),
    .rxFrameErr(rxFrameErr), .rxOverrun(rxOverrun)
  );
endmodule

// File: rtl/cfg_uart_chk.sv
module cfg_uart_chk (
  input logic clk,
  input logic rst,
  input logic txIdle,
  input logic txd,
  input logic rxAvail,
  input logic rxRead,
  input logic rxOverrun
);
  AST_IDLE_LINE_HIGH: assert property (@(posedge clk) disable iff (rst)
    txIdle |-> txd); // R2
  AST_START_AFTER_LOAD: assert property (@(posedge clk) disable iff (rst)
    $fell(txIdle) |-> !txd); // R2
  AST_STOP_BEFORE_IDLE: assert property (@(posedge clk) disable iff (rst)
    $rose(txIdle) |-> $past(txd)); // R4
  AST_AVAIL_DROP_ON_READ: assert property (@(posedge clk) disable iff (rst)
    $fell(rxAvail) |-> $past(rxRead)); // R10
  AST_OVERRUN_WHEN_HELD: assert property (@(posedge clk) disable iff (rst)
    $rose(rxOverrun) |-> rxAvail); // R11
  AST_OVERRUN_CLEARED: assert property (@(posedge clk) disable iff (rst)
    rxRead |=> !rxOverrun); // R11
endmodule

bind cfg_uart cfg_uart_chk uChk (
  .clk(clk), .rst(rst), .txIdle(txIdle), .txd(txd),
  .rxAvail(rxAvail), .rxRead(rxRead), .rxOverrun(rxOverrun)
);

// File: tb/tb_cfg_uart.sv
module tb_cfg_uart;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [2:0] cfgLen = 3'd3;
  logic [2:0] cfgParity = 3'd0;
  logic cfgStop2 = 1'b0;
  logic [1:0] cfgPrescale = 2'd0;
  logic [15:0] cfgReload = 16'hFFFE;
  logic [8:0] txData = '0;
  logic txWrite = 1'b0;
  logic rxd = 1'b1;
  logic rxRead = 1'b0;
  logic txIdle, txd, rxAvail, rxParErr, rxFrameErr, rxOverrun;
  logic [8:0] rxData;

  int testsRun = 0;
  int testsFailed = 0;
  int bitClk = 16;
  int tickClk = 2;
  bit rxBusy = 1'b0;
  bit readBusy = 1'b0;
  bit cmpOn = 1'b0;
  bit finished = 1'b0;

  int qData[$];
  int qPe[$];
  int qFe[$];
  int modelOvr = 0;

  cfg_uart dut (
    .clk(clk), .rst(rst), .cfgLen(cfgLen), .cfgParity(cfgParity),
    .cfgStop2(cfgStop2), .cfgPrescale(cfgPrescale), .cfgReload(cfgReload),
    .txData(txData), .txWrite(txWrite), .txIdle(txIdle), .txd(txd),
    .rxd(rxd), .rxRead(rxRead), .rxData(rxData), .rxAvail(rxAvail),
    .rxParErr(rxParErr), .rxFrameErr(rxFrameErr), .rxOverrun(rxOverrun)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string what, input int act, input int exp);
    testsRun++;
    if (act != exp) begin
      testsFailed++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  task automatic finishRun();
    if (!finished) begin
      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  endtask

  task automatic waitClk(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  function automatic int bpar(input int pm, input int d, input int nb);
    int x;
    x = ^(d & ((1 << nb) - 1));
    case (pm)
      1: return x ^ 1;
      2: return x;
      3: return 1;
      default: return 0;
    endcase
  endfunction

  task automatic setCfg(input int len, input int pm, input bit st2, input int pre, input int rl);
    cfgLen = 3'(len);
    cfgParity = 3'(pm);
    cfgStop2 = st2;
    cfgPrescale = 2'(pre);
    cfgReload = 16'(rl);
    tickClk = (65536 - rl) * (1 << pre);
    bitClk = tickClk * 8;
    waitClk(2 * bitClk);
  endtask

  // every idle clock: queue occupancy and overrun against the model (R10, R11)
  always @(negedge clk) begin
    if (!rst && cmpOn && !rxBusy && !readBusy) begin
      check("R10 rxAvail vs model", int'(rxAvail), int'(qData.size() > 0));
      check("R11 rxOverrun vs model", int'(rxOverrun), modelOvr);
    end
  end

  task automatic txFrame(input int d, input int len, input int pm, input bit st2,
                         input bit poke);
    int nb;
    nb = len + 5;
    txData = 9'(d);
    txWrite = 1'b1;
    waitClk(1);
    txWrite = 1'b0;
    check("R2 txIdle low after write", int'(txIdle), 0);
    waitClk(bitClk / 2);
    check("R2 start bit low", int'(txd), 0);
    for (int i = 0; i < nb; i++) begin
      waitClk(bitClk);
      check($sformatf("R2 data bit %0d", i), int'(txd), (d >> i) & 1);
      if (poke && i == 0) begin
        txData = 9'(~d);
        txWrite = 1'b1;
        waitClk(1);
        txWrite = 1'b0;
      end
    end
    if (pm != 0) begin
      waitClk(bitClk);
      check($sformatf("R3 parity bit mode %0d", pm), int'(txd), bpar(pm, d, nb));
    end
    waitClk(bitClk);
    check("R4 first stop high", int'(txd), 1);
    check("R4 busy in first stop", int'(txIdle), 0);
    if (st2) begin
      waitClk(bitClk);
      check("R4 second stop high", int'(txd), 1);
      check("R4 busy in second stop", int'(txIdle), 0);
    end
    waitClk(bitClk * 5 / 8);
    check("R4 idle after last stop", int'(txIdle), 1);
  endtask

  task automatic rxFrame(input int d, input int len, input int pm, input bit badPar,
                         input bit badStop);
    int nb;
    int pb;
    nb = len + 5;
    rxBusy = 1'b1;
    rxd = 1'b0;
    waitClk(bitClk);
    for (int i = 0; i < nb; i++) begin
      rxd = 1'((d >> i) & 1);
      waitClk(bitClk);
    end
    if (pm != 0) begin
      pb = bpar(pm, d, nb);
      rxd = 1'(badPar ? pb ^ 1 : pb);
      waitClk(bitClk);
    end
    rxd = badStop ? 1'b0 : 1'b1;
    waitClk(bitClk);
    rxd = 1'b1;
    waitClk(bitClk);
    if (qData.size() < 3) begin
      qData.push_back(d & ((1 << nb) - 1));
      qPe.push_back(int'(badPar && pm != 0));
      qFe.push_back(int'(badStop));
    end else begin
      modelOvr = 1;
    end
    rxBusy = 1'b0;
  endtask

  task automatic readHead(input string tag);
    int ed, ep, ef;
    readBusy = 1'b1;
    check({tag, " entry available"}, int'(rxAvail), 1);
    ed = (qData.size() > 0) ? qData.pop_front() : -1;
    ep = (qPe.size() > 0) ? qPe.pop_front() : -1;
    ef = (qFe.size() > 0) ? qFe.pop_front() : -1;
    check({tag, " rxData"}, int'(rxData), ed);
    check({tag, " rxParErr"}, int'(rxParErr), ep);
    check({tag, " rxFrameErr"}, int'(rxFrameErr), ef);
    rxRead = 1'b1;
    modelOvr = 0;
    waitClk(1);
    rxRead = 1'b0;
    readBusy = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    testsRun++;
    testsFailed++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    int lowLen;
    // R1 reset state
    waitClk(2);
    check("R1 txd in reset", int'(txd), 1);
    check("R1 txIdle in reset", int'(txIdle), 1);
    rst = 1'b0;
    waitClk(1);
    check("R1 txd", int'(txd), 1);
    check("R1 txIdle", int'(txIdle), 1);
    check("R1 rxAvail", int'(rxAvail), 0);
    check("R1 rxOverrun", int'(rxOverrun), 0);
    cmpOn = 1'b1;

    // R2 8N1 transmit, then a busy write that must be ignored
    setCfg(3, 0, 0, 0, 16'hFFFE);
    txFrame(9'h0A5, 3, 0, 0, 0);
    txFrame(9'h03C, 3, 0, 0, 1);
    waitClk(2 * bitClk);
    check("R2 busy write ignored idle", int'(txIdle), 1);
    check("R2 busy write ignored line", int'(txd), 1);

    // R3 parity modes and lengths
    setCfg(0, 1, 0, 0, 16'hFFFE);
    txFrame(9'h013, 0, 1, 0, 0);
    setCfg(2, 2, 0, 0, 16'hFFFE);
    txFrame(9'h05B, 2, 2, 0, 0);
    setCfg(1, 3, 0, 0, 16'hFFFE);
    txFrame(9'h02A, 1, 3, 0, 0);
    setCfg(4, 4, 0, 0, 16'hFFFE);
    txFrame(9'h1A5, 4, 4, 0, 0);

    // R4 two stop bits
    setCfg(3, 2, 1, 0, 16'hFFFE);
    txFrame(9'h081, 3, 2, 1, 0);

    // R5 rate from reload and prescaler: low span of an all-zero 8N1 frame
    setCfg(3, 0, 0, 1, 16'hFFFD);
    txData = 9'h000;
    txWrite = 1'b1;
    waitClk(1);
    txWrite = 1'b0;
    lowLen = 1;
    while (txd == 1'b0 && lowLen < 2000) begin
      waitClk(1);
      lowLen++;
    end
    lowLen--;
    check("R5 low span upper bound", int'(lowLen <= 9 * bitClk), 1);
    check("R5 low span lower bound", int'(lowLen >= 9 * bitClk - tickClk + 1), 1);
    waitClk(2 * bitClk);
    txFrame(9'h0C3, 3, 0, 0, 0);

    // R6 receive alignment at three lengths
    setCfg(3, 0, 0, 0, 16'hFFFE);
    rxFrame(9'h03C, 3, 0, 0, 0);
    readHead("R6 8-bit");
    setCfg(0, 0, 0, 0, 16'hFFFE);
    rxFrame(9'h1FF, 0, 0, 0, 0);
    readHead("R6 5-bit upper zero");
    setCfg(4, 2, 0, 0, 16'hFFFE);
    rxFrame(9'h155, 4, 2, 0, 0);
    readHead("R6 9-bit even");

    // R7 parity error per entry
    setCfg(2, 1, 0, 0, 16'hFFFE);
    rxFrame(9'h04D, 2, 1, 1, 0);
    rxFrame(9'h012, 2, 1, 0, 0);
    readHead("R7 bad parity");
    readHead("R7 good parity");
    setCfg(3, 3, 0, 0, 16'hFFFE);
    rxFrame(9'h011, 3, 3, 1, 0);
    readHead("R7 mark mismatch");

    // R8 framing error, then a clean frame
    setCfg(3, 0, 0, 0, 16'hFFFE);
    rxFrame(9'h066, 3, 0, 0, 1);
    rxFrame(9'h099, 3, 0, 0, 0);
    readHead("R8 low stop");
    readHead("R8 after break");

    // R9 short low pulse is ignored
    rxd = 1'b0;
    waitClk(4);
    rxd = 1'b1;
    waitClk(2 * bitClk);
    check("R9 glitch stored nothing", int'(rxAvail), 0);
    rxFrame(9'h0E7, 3, 0, 0, 0);
    readHead("R9 frame after glitch");

    // R10 order of three entries
    rxFrame(9'h001, 3, 0, 0, 0);
    rxFrame(9'h080, 3, 0, 0, 0);
    rxFrame(9'h0F0, 3, 0, 0, 0);
    check("R10 no overrun at three", int'(rxOverrun), 0);
    readHead("R10 first");
    readHead("R10 second");
    readHead("R10 third");

    // R11 fourth frame lost
    rxFrame(9'h011, 3, 0, 0, 0);
    rxFrame(9'h022, 3, 0, 0, 0);
    rxFrame(9'h033, 3, 0, 0, 0);
    rxFrame(9'h044, 3, 0, 0, 0);
    check("R11 overrun set", int'(rxOverrun), 1);
    readHead("R11 head kept");
    check("R11 overrun cleared by read", int'(rxOverrun), 0);
    readHead("R11 second kept");
    readHead("R11 third kept");
    waitClk(4);
    check("R11 lost frame absent", int'(rxAvail), 0);

    finishRun();
  end
endmodule